// File: doc/BRIEF.md
# I2C Target Byte Engine

This block is the bit-level engine of an I2C target (slave). A fast system clock oversamples the SCL and SDA lines through a synchronizer. The engine finds START and STOP conditions, shifts bytes in on SCL rising edges and answers each byte with an ACK or a NACK. The pads are open-drain, so the block never drives a line high. It only raises a separate pull-low enable for each line, and the pad or bench forms the wired-AND bus.

The first byte after a START is an address byte. It goes to a matcher that supports a 7-bit own address or a two-byte 10-bit write address. Data bytes written by the controller go into a one-entry holding register. That register has a full flag and a sticky overflow flag, and these two flags decide whether a byte is loaded and whether it is acknowledged. When the controller asks to read, the engine holds SCL low until the host supplies a byte and requests release. It then shifts the byte out MSB first. A one-cycle event pulse marks the end of every handled byte.

Top module: `i2c_tgt_engine`

## Requirements
- R1: After reset, and in any cycle after `en` is low, both pull-low enables are released and `evt_pulse` is low. Reset also clears `rx_full` and `rx_ovf`.
- R2: With `en` high, a START (SDA falling while SCL is high) begins an address byte. Bits are sampled on SCL rising edges, MSB first. In 7-bit mode (`ten_bit`=0), a byte whose bits 7:1 equal `own_addr[6:0]` is acknowledged by pulling SDA low during the ninth SCL clock. Bit 0 is the read/write bit, and 1 means read.
- R3: An address byte that does not match gets no ACK and no event pulse. The engine then leaves both lines alone until the next START or STOP.
- R4: An acknowledged address byte gives one `evt_pulse` of a single cycle on the falling edge of the ninth SCL clock. It never changes `rx_data` or `rx_full`.
- R5: A data byte that completes while `rx_full`=0 and `rx_ovf`=0 is copied to `rx_data`, sets `rx_full` and is acknowledged.
- R6: A data byte that completes while `rx_full`=1 is not acknowledged and not loaded. It sets `rx_ovf`, and `evt_pulse` still fires.
- R7: A data byte that completes while `rx_ovf`=1 and `rx_full`=0 is loaded into `rx_data` and sets `rx_full`, but it is not acknowledged.
- R8: A one-cycle `rx_rd` pulse clears `rx_full`. `rx_ovf` is cleared only by an `ovf_clr` pulse.
- R9: After an acknowledged read address, the engine holds SCL low. It keeps holding until `tx_rel` is pulsed after `tx_wr` has loaded a byte. A `tx_rel` with no byte loaded is ignored.
- R10: A transmitted byte is sent MSB first, and SDA changes only while SCL is low.
- R11: In transmit, `evt_pulse` fires on the ninth SCL falling edge whether the controller ACKs or NACKs. After an ACK the engine stretches SCL again for the next byte. After a NACK it drives nothing until the next START or STOP.
- R12: In 10-bit mode (`ten_bit`=1), the first address byte must be 11110, then `own_addr[9:8]`, then a 0 write bit. The second byte must equal `own_addr[7:0]`. Each matching byte is acknowledged. A mismatching byte gets no ACK, and the engine ignores the rest of the transfer.
- R13: A STOP (SDA rising while SCL is high) returns the engine to idle and releases both lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Engine enable |
| ten_bit | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Own address; 7-bit mode uses bits 6:0 |
| scl_in | input | 1 | SCL level seen at the pad |
| sda_in | input | 1 | SDA level seen at the pad |
| scl_drive_low | output | 1 | Pull SCL low (clock stretch) |
| sda_drive_low | output | 1 | Pull SDA low (ACK or data 0) |
| rx_data | output | 8 | Receive holding register |
| rx_full | output | 1 | Holding register contains unread data |
| rx_ovf | output | 1 | Sticky overflow flag |
| rx_rd | input | 1 | Host read pulse, clears full |
| ovf_clr | input | 1 | Host pulse clearing overflow |
| tx_data | input | 8 | Byte to transmit |
| tx_wr | input | 1 | Loads `tx_data` into the transmit buffer |
| tx_rel | input | 1 | Host release request for a stretched SCL |
| evt_pulse | output | 1 | One-cycle per-byte event |

## Verification
The hardest state to reach is an overflow flag that is set while the holding register is empty. The host must read the register but leave the flag set, and the next byte must then be loaded yet refused. The bench reaches this state with a table of data bytes inside one write transfer. Each entry states whether the host reads and whether it clears overflow before the byte. The table first fills the register, then overflows it, then reads it without clearing, so the loaded-but-NACKed case follows from the earlier entries. Clock stretching is checked by releasing SCL from the controller model, then confirming the bus stays low through an early release request and only rises once a byte is loaded.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = 4;
    localparam int ADDR_W = 10;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX_HOLD,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } eng_st_e;

    typedef struct packed {
        eng_st_e             st;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sr;
        logic                rw;
        logic                second;
        logic                ack_drv;
        logic [BYTE_W-1:0]   tx_buf;
        logic                tx_ld;
        logic [BYTE_W-1:0]   tx_sr;
        logic                mack;
        logic                evt;
    } eng_t;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              full;
        logic              ovf;
    } rxh_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] scl_ff_d, scl_ff_q;
    logic [STAGES-1:0] sda_ff_d, sda_ff_q;
    logic              scl_p_d, scl_p_q;
    logic              sda_p_d, sda_p_q;

    generate
        if (STAGES > 1) begin : g_chain
            always_comb begin
                scl_ff_d = {scl_ff_q[STAGES-2:0], scl_in};
                sda_ff_d = {sda_ff_q[STAGES-2:0], sda_in};
            end
        end else begin : g_single
            always_comb begin
                scl_ff_d = scl_in;
                sda_ff_d = sda_in;
            end
        end
    endgenerate

    always_comb begin
        scl_p_d = scl_ff_q[LAST];
        sda_p_d = sda_ff_q[LAST];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff_q <= '1;
            sda_ff_q <= '1;
            scl_p_q  <= 1'b1;
            sda_p_q  <= 1'b1;
        end else begin
            scl_ff_q <= scl_ff_d;
            sda_ff_q <= sda_ff_d;
            scl_p_q  <= scl_p_d;
            sda_p_q  <= sda_p_d;
        end
    end

    assign scl_s     = scl_ff_q[LAST];
    assign sda_s     = sda_ff_q[LAST];
    assign scl_rise  = scl_s & ~scl_p_q;
    assign scl_fall  = ~scl_s & scl_p_q;
    assign start_det = scl_s & scl_p_q & sda_p_q & ~sda_s;
    assign stop_det  = scl_s & scl_p_q & ~sda_p_q & sda_s;

endmodule

// File: rtl/i2c_tgt_addr_match.sv
module i2c_tgt_addr_match
    import i2c_tgt_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              ten_bit,
    input  logic              second,
    output logic              hit
);
    localparam logic [4:0] TEN_BIT_TAG = 5'b11110;

    always_comb begin
        if (!ten_bit) begin
            hit = (addr_byte[7:1] == own_addr[6:0]);
        end else if (!second) begin
            // R12: first byte is tag, two high address bits, write bit
            hit = (addr_byte[7:3] == TEN_BIT_TAG) &&
                  (addr_byte[2:1] == own_addr[9:8]) &&
                  !addr_byte[0];
        end else begin
            hit = (addr_byte == own_addr[7:0]);
        end
    end

endmodule

// File: rtl/i2c_tgt_rx_hold.sv
module i2c_tgt_rx_hold
    import i2c_tgt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              rd,
    input  logic              ovf_clr,
    output logic              ack_ok,
    output logic [BYTE_W-1:0] data,
    output logic              full,
    output logic              ovf
);
    rxh_t d, q;

    always_comb begin
        d = q;
        if (rd) begin
            d.full = 1'b0;
        end
        if (ovf_clr) begin
            d.ovf = 1'b0;
        end
        if (commit) begin
            if (q.full) begin
                d.ovf = 1'b1;
            end else begin
                d.data = byte_in;
                d.full = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign ack_ok = ~q.full & ~q.ovf;
    assign data   = q.data;
    assign full   = q.full;
    assign ovf    = q.ovf;

    p_full_no_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && q.full) |=> (q.data == $past(q.data)) && q.ovf);

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.ovf && !ovf_clr) |=> q.ovf);

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              ten_bit,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    output logic [BYTE_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovf,
    input  logic              rx_rd,
    input  logic              ovf_clr,
    input  logic [BYTE_W-1:0] tx_data,
    input  logic              tx_wr,
    input  logic              tx_rel,
    output logic              evt_pulse
);
    localparam logic [CNT_W-1:0] BITS_IN  = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_OUT = CNT_W'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic addr_hit, rx_ack_ok, commit;
    eng_t d, q;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_tgt_addr_match u_match (
        .addr_byte (q.sr),
        .own_addr  (own_addr),
        .ten_bit   (ten_bit),
        .second    (q.second),
        .hit       (addr_hit)
    );

    i2c_tgt_rx_hold u_rxh (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .byte_in (q.sr),
        .rd      (rx_rd),
        .ovf_clr (ovf_clr),
        .ack_ok  (rx_ack_ok),
        .data    (rx_data),
        .full    (rx_full),
        .ovf     (rx_ovf)
    );

    always_comb begin
        d      = q;
        d.evt  = 1'b0;
        commit = 1'b0;

        if (tx_wr) begin
            d.tx_buf = tx_data;
            d.tx_ld  = 1'b1;
        end

        if (!en) begin
            d.st      = ST_IDLE;
            d.ack_drv = 1'b0;
            d.cnt     = '0;
        end else if (start_det) begin
            d.st      = ST_ADDR;
            d.cnt     = '0;
            d.ack_drv = 1'b0;
            d.second  = 1'b0;
        end else if (stop_det) begin
            d.st      = ST_IDLE;
            d.ack_drv = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR: begin
                    if (scl_rise && q.cnt < BITS_IN) begin
                        d.sr  = {q.sr[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_IN) begin
                        if (addr_hit) begin
                            d.ack_drv = 1'b1;
                            d.st      = ST_ADDR_ACK;
                            if (!q.second) begin
                                d.rw = q.sr[0];
                            end
                        end else begin
                            d.st = ST_IGNORE;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        d.ack_drv = 1'b0;
                        d.evt     = 1'b1;
                        d.cnt     = '0;
                        if (ten_bit && !q.second) begin
                            d.second = 1'b1;
                            d.st     = ST_ADDR;
                        end else if (q.rw) begin
                            d.st = ST_TX_HOLD;
                        end else begin
                            d.st = ST_RX;
                        end
                    end
                end
                ST_RX: begin
                    if (scl_rise && q.cnt < BITS_IN) begin
                        d.sr  = {q.sr[BYTE_W-2:0], sda_s};
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall && q.cnt == BITS_IN) begin
                        commit    = 1'b1;
                        d.ack_drv = rx_ack_ok;
                        d.st      = ST_RX_ACK;
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        d.ack_drv = 1'b0;
                        d.evt     = 1'b1;
                        d.cnt     = '0;
                        d.st      = ST_RX;
                    end
                end
                ST_TX_HOLD: begin
                    if (tx_rel && q.tx_ld) begin
                        d.tx_sr = q.tx_buf;
                        d.tx_ld = tx_wr;
                        d.cnt   = '0;
                        d.st    = ST_TX;
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == LAST_OUT) begin
                            d.st = ST_TX_ACK;
                        end else begin
                            d.tx_sr = {q.tx_sr[BYTE_W-2:0], 1'b0};
                            d.cnt   = q.cnt + 1'b1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        d.evt = 1'b1;
                        d.st  = q.mack ? ST_TX_HOLD : ST_IGNORE;
                    end
                end
                default: begin
                    d.ack_drv = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign scl_drive_low = (q.st == ST_TX_HOLD);
    assign sda_drive_low = q.ack_drv | ((q.st == ST_TX) & ~q.tx_sr[BYTE_W-1]);
    assign evt_pulse     = q.evt;

    p_disabled_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!scl_drive_low && !sda_drive_low && !evt_pulse));

    p_evt_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pulse |=> !evt_pulse);

    p_tx_sda_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_TX && $past(q.st) == ST_TX && scl_s && $past(scl_s))
        |-> (sda_drive_low == $past(sda_drive_low)));

    p_stop_release_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (en && stop_det) |=> (!scl_drive_low && !sda_drive_low));

endmodule

// File: tb/i2c_tgt_engine_bench.sv
module i2c_tgt_engine_bench;
    localparam int HALF = 10;
    localparam int NVEC = 6;
    // {rd_before, clr_before, byte, exp_ack, exp_full, exp_ovf, exp_data}
    localparam logic [20:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 8'h11},
        {1'b0, 1'b0, 8'h22, 1'b0, 1'b1, 1'b1, 8'h11},
        {1'b1, 1'b0, 8'h33, 1'b0, 1'b1, 1'b1, 8'h33},
        {1'b1, 1'b1, 8'h44, 1'b1, 1'b1, 1'b0, 8'h44},
        {1'b1, 1'b0, 8'h55, 1'b1, 1'b1, 1'b0, 8'h55},
        {1'b0, 1'b0, 8'h66, 1'b0, 1'b1, 1'b1, 8'h55}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, ten_bit = 1'b0;
    logic [9:0] own_addr = 10'h03C;
    logic m_scl_low = 1'b0, m_sda_low = 1'b0;
    logic scl_bus, sda_bus;
    logic scl_drive_low, sda_drive_low;
    logic [7:0] rx_data;
    logic rx_full, rx_ovf;
    logic rx_rd = 1'b0, ovf_clr = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic tx_wr = 1'b0, tx_rel = 1'b0;
    logic evt_pulse;

    int total = 0, fails = 0, evt_cnt = 0, cyc = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign scl_bus = ~(m_scl_low | scl_drive_low);
    assign sda_bus = ~(m_sda_low | sda_drive_low);

    i2c_tgt_engine u_i2c_tgt_engine (
        .clk(clk), .rst_n(rst_n), .en(en), .ten_bit(ten_bit), .own_addr(own_addr),
        .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low),
        .rx_data(rx_data), .rx_full(rx_full), .rx_ovf(rx_ovf),
        .rx_rd(rx_rd), .ovf_clr(ovf_clr),
        .tx_data(tx_data), .tx_wr(tx_wr), .tx_rel(tx_rel),
        .evt_pulse(evt_pulse)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (evt_pulse) evt_cnt <= evt_cnt + 1;
        if (cyc == 150000 && !done) begin
            done = 1'b1;
            fails = fails + 1;
            total = total + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion earlier", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total = total + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bit_clk(input logic b, output logic smp);
        m_sda_low = ~b;
        idle(HALF);
        m_scl_low = 1'b0;
        for (int i = 0; i < 4000 && !scl_bus; i++) @(negedge clk);
        idle(HALF / 2);
        smp = sda_bus;
        idle(HALF / 2);
        m_scl_low = 1'b1;
        idle(HALF);
    endtask

    task automatic do_start();
        m_sda_low = 1'b0;
        idle(HALF);
        m_scl_low = 1'b0;
        idle(HALF);
        m_sda_low = 1'b1;
        idle(HALF);
        m_scl_low = 1'b1;
        idle(HALF);
    endtask

    task automatic do_stop();
        m_sda_low = 1'b1;
        idle(HALF);
        m_scl_low = 1'b0;
        idle(HALF);
        m_sda_low = 1'b0;
        idle(HALF);
    endtask

    task automatic wr_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_clk(v[i], s);
        bit_clk(1'b1, s);
        acked = ~s;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_clk(1'b1, s);
            v[i] = s;
        end
        bit_clk(~give_ack, s);
    endtask

    task automatic pulse_rd();
        @(negedge clk) rx_rd = 1'b1;
        @(negedge clk) rx_rd = 1'b0;
    endtask

    task automatic pulse_clr();
        @(negedge clk) ovf_clr = 1'b1;
        @(negedge clk) ovf_clr = 1'b0;
    endtask

    task automatic host_tx(input logic [7:0] v);
        @(negedge clk) begin tx_data = v; tx_wr = 1'b1; end
        @(negedge clk) tx_wr = 1'b0;
        @(negedge clk) tx_rel = 1'b1;
        @(negedge clk) tx_rel = 1'b0;
    endtask

    initial begin
        logic ack;
        logic [7:0] rb;
        int e0;

        idle(5);
        rst_n = 1'b1;
        idle(3);
        // R1: reset state
        chk("R1 scl released after reset", scl_drive_low, 0);
        chk("R1 sda released after reset", sda_drive_low, 0);
        chk("R1 full clear after reset", rx_full, 0);
        chk("R1 ovf clear after reset", rx_ovf, 0);
        en = 1'b1;
        idle(5);

        // R3: mismatching 7-bit address 0x3D
        e0 = evt_cnt;
        do_start();
        wr_byte(8'h7A, ack);
        chk("R3 no ack for other address", ack, 0);
        chk("R3 no event for other address", evt_cnt - e0, 0);
        chk("R3 rx untouched", rx_full, 0);
        do_stop();

        // R2/R4: matching write address then table of data bytes (R5..R8)
        e0 = evt_cnt;
        do_start();
        wr_byte(8'h78, ack);
        chk("R2 ack for own address", ack, 1);
        chk("R4 one event for address", evt_cnt - e0, 1);
        chk("R4 address leaves full clear", rx_full, 0);
        for (int k = 0; k < NVEC; k++) begin
            if (VEC[k][20]) pulse_rd();
            if (VEC[k][19]) pulse_clr();
            e0 = evt_cnt;
            wr_byte(VEC[k][18:11], ack);
            chk($sformatf("R5/R6/R7 ack vec %0d", k), ack, VEC[k][10]);
            chk($sformatf("R5/R6/R7 full vec %0d", k), rx_full, VEC[k][9]);
            chk($sformatf("R6/R8 ovf vec %0d", k), rx_ovf, VEC[k][8]);
            chk($sformatf("R5/R6/R7 data vec %0d", k), rx_data, VEC[k][7:0]);
            chk($sformatf("R6 event vec %0d", k), evt_cnt - e0, 1);
        end
        do_stop();
        idle(5);
        chk("R13 lines released after stop", {scl_drive_low, sda_drive_low}, 0);

        // R4: address byte with full holding register leaves it alone
        do_start();
        wr_byte(8'h78, ack);
        chk("R4 full kept across address", rx_full, 1);
        chk("R4 data kept across address", rx_data, 8'h55);
        do_stop();

        // R8: read clears full, overflow stays until cleared
        pulse_rd();
        idle(2);
        chk("R8 read clears full", rx_full, 0);
        chk("R8 ovf survives read", rx_ovf, 1);
        pulse_clr();
        idle(2);
        chk("R8 ovf cleared by clear pulse", rx_ovf, 0);

        // R9/R10/R11: read transfer with stretching
        do_start();
        e0 = evt_cnt;
        wr_byte(8'h79, ack);
        chk("R9 ack for read address", ack, 1);
        chk("R4 event for read address", evt_cnt - e0, 1);
        m_scl_low = 1'b0;
        idle(40);
        chk("R9 scl held low before data", scl_bus, 0);
        @(negedge clk) tx_rel = 1'b1;
        @(negedge clk) tx_rel = 1'b0;
        idle(40);
        chk("R9 release without byte ignored", scl_bus, 0);
        m_scl_low = 1'b1;
        host_tx(8'hA5);
        idle(4);
        chk("R9 scl freed after write and release", scl_drive_low, 0);
        e0 = evt_cnt;
        rd_byte(1'b1, rb);
        chk("R10 first byte MSB first", rb, 8'hA5);
        chk("R11 event after acked byte", evt_cnt - e0, 1);
        m_scl_low = 1'b0;
        idle(40);
        chk("R11 stretch again after ack", scl_bus, 0);
        m_scl_low = 1'b1;
        host_tx(8'h3C);
        e0 = evt_cnt;
        rd_byte(1'b0, rb);
        chk("R10 second byte", rb, 8'h3C);
        chk("R11 event after nacked byte", evt_cnt - e0, 1);
        m_sda_low = 1'b0;
        idle(5);
        chk("R11 sda free after nack", sda_drive_low, 0);
        m_scl_low = 1'b0;
        idle(40);
        chk("R11 no stretch after nack", scl_bus, 1);
        m_scl_low = 1'b1;
        idle(HALF);
        do_stop();

        // R12: 10-bit addressing
        ten_bit = 1'b1;
        own_addr = 10'h2B7;
        do_start();
        wr_byte(8'hF4, ack);
        chk("R12 first 10-bit byte ack", ack, 1);
        wr_byte(8'hB7, ack);
        chk("R12 second 10-bit byte ack", ack, 1);
        wr_byte(8'h5A, ack);
        chk("R12 data after 10-bit address ack", ack, 1);
        chk("R12 data loaded", rx_data, 8'h5A);
        do_stop();
        pulse_rd();
        do_start();
        wr_byte(8'hF4, ack);
        wr_byte(8'hB6, ack);
        chk("R12 wrong low byte nack", ack, 0);
        wr_byte(8'h77, ack);
        chk("R12 ignored after mismatch", ack, 0);
        chk("R12 rx untouched after mismatch", rx_full, 0);
        do_stop();
        wr_byte(8'hF5, ack);
        do_start();
        wr_byte(8'hF5, ack);
        chk("R12 10-bit read-first byte nack", ack, 0);
        do_stop();

        // R1: disable during stretch releases SCL
        ten_bit = 1'b0;
        own_addr = 10'h03C;
        do_start();
        wr_byte(8'h79, ack);
        idle(5);
        chk("R9 stretching in hold", scl_drive_low, 1);
        en = 1'b0;
        idle(3);
        chk("R1 disable releases scl", scl_drive_low, 0);
        chk("R1 disable releases sda", sda_drive_low, 0);
        m_scl_low = 1'b0;
        idle(HALF);
        m_sda_low = 1'b0;
        idle(HALF);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule